// File: doc/BRIEF.md
# Conditional opcode bit inverter

This block sits in the read path of the data bus, between program memory and a processor of the 65xx family. The processor's reserved two-byte instruction (opcode 42h) acts as a trigger. When the block sees that opcode on an opcode-fetch cycle, it takes the following program byte as a command. That byte names one bit of an output port to write and one bit of an input port to sample, and both happen in the same bus cycle. If the sampled bit is 1, the block changes the next instruction on its way to the processor. It either inverts bit 5 of that instruction's opcode or inverts every bit of its second byte. Software can then pick one of two paired instructions without a branch.

Cycle type comes either from the two 65816 program/data strobes or from the single 6502 sync strobe, selected by a mode pin. Cycles other than the target are passed through unchanged: data reads, writes and dead cycles. An interrupt can land between the trigger and its target, so its vector fetch would otherwise steal the target. If a vector pull appears while a change is still outstanding, the change is dropped and a sticky flag records the drop. Software never has to mask interrupts.

Top module: `opcode_flip_gate`

## Requirements
- R1: An opcode fetch is a read cycle (rwb=1) with vda=1 and vpa=1 when mode_816=1, or with sync=1 when mode_816=0. Only an opcode fetch carrying 42h arms the block. The next cycle is then taken as the command byte, provided it is a program read: vpa=1 and vda=0 in 65816 mode, or sync=0 in 6502 mode.
- R2: The command byte has these fields. Bits 5:3 give the output port bit index and bit 6 gives the value written to it. That port bit changes at the clock edge ending the command cycle, and the other port bits hold.
- R3: Command bits 2:0 select the input port bit sampled during the command cycle. If that bit is 1 and command bit 7 is 0, the next opcode fetch reaches cpu_data with bit 5 inverted (mem_data ^ 20h).
- R4: If the sampled input bit is 0, no later byte is altered.
- R5: If the sampled input bit is 1 and command bit 7 is 1, the next opcode passes unchanged. The program read right after it reaches cpu_data fully inverted (mem_data ^ FFh).
- R6: One trigger alters at most one byte. Later opcode and operand fetches pass unchanged.
- R7: While a change is outstanding, data reads (vda=1, vpa=0), dead cycles (vda=vpa=0) and writes (rwb=0) pass unchanged.
- R8: A vector pull (vec_pull=1) while a change is outstanding cancels it and sets cancel_flag. This holds before the target byte and also between the altered opcode and the next opcode fetch. cancel_flag stays set until reset.
- R9: 42h read on a cycle that is not an opcode fetch does not arm the block.
- R10: Reset clears port_out to 00h and cancel_flag to 0, and discards any armed or outstanding change.
- R11: In 6502 mode the vda/vpa pins have no effect on classification. In 65816 mode sync has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_816 | input | 1 | 1: classify with vda/vpa, 0: classify with sync |
| sync | input | 1 | 6502 opcode-fetch strobe |
| vda | input | 1 | 65816 valid data address strobe |
| vpa | input | 1 | 65816 valid program address strobe |
| rwb | input | 1 | 1 read, 0 write |
| vec_pull | input | 1 | High during an interrupt vector fetch |
| mem_data | input | 8 | Byte from memory |
| port_in | input | 8 | Input port sampled by the command |
| cpu_data | output | 8 | Byte delivered to the processor |
| port_out | output | 8 | Output port written by the command |
| cancel_flag | output | 1 | Sticky record of a dropped change |

## Verification
A wrong internal state shows up on cpu_data within one bus cycle. A stale or missing pending state makes the target opcode keep bit 5, or makes a later opcode lose it. A misplaced operand-mode state inverts the wrong byte, or inverts a data read. Misclassified strobes show up the same way, through arming on a data read or flipping a dead cycle. A wrong command decode shows on port_out at the edge that ends the command cycle. Lost cancellation appears as a flipped opcode after a vector pull, together with cancel_flag staying low.

// File: rtl/opcode_flip_gate.sv
module opcode_flip_gate #(
  parameter int          DW         = 8,
  parameter logic [7:0]  TRIGGER_OP = 8'h42,
  parameter int          FLIP_BIT   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_816,
  input  logic          sync,
  input  logic          vda,
  input  logic          vpa,
  input  logic          rwb,
  input  logic          vec_pull,
  input  logic [DW-1:0] mem_data,
  input  logic [DW-1:0] port_in,
  output logic [DW-1:0] cpu_data,
  output logic [DW-1:0] port_out,
  output logic          cancel_flag
);

  localparam int SW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_PEND_OP, S_PEND_ARG, S_WATCH} state_t;

  state_t state;
  logic   arg_mode;

  logic op_fetch, prog_read;
  assign op_fetch  = rwb & (mode_816 ? (vda & vpa) : sync);
  assign prog_read = rwb & (mode_816 ? (vpa & ~vda) : ~sync);

  logic [SW-1:0] sel_in, sel_out;
  logic          cmd_val, cmd_arg, hit;
  assign sel_in  = mem_data[SW-1:0];
  assign sel_out = mem_data[2*SW-1:SW];
  assign cmd_val = mem_data[2*SW];
  assign cmd_arg = mem_data[2*SW+1];
  assign hit     = port_in[sel_in];

  logic flip_op, flip_arg;
  assign flip_op  = (state == S_PEND_OP)  & ~arg_mode & op_fetch  & ~vec_pull;
  assign flip_arg = (state == S_PEND_ARG) & prog_read & ~vec_pull;

  logic [DW-1:0] mask;
  assign mask     = {DW{flip_arg}} | (DW'(flip_op) << FLIP_BIT);
  assign cpu_data = mem_data ^ mask;

  logic outstanding;
  assign outstanding = (state == S_PEND_OP) | (state == S_PEND_ARG) | (state == S_WATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      arg_mode    <= 1'b0;
      port_out    <= '0;
      cancel_flag <= 1'b0;
    end else begin
      if (vec_pull && outstanding) begin
        state       <= S_IDLE;
        cancel_flag <= 1'b1;
      end else begin
        unique case (state)
          S_IDLE, S_WATCH: begin
            if (op_fetch)
              state <= (mem_data == TRIGGER_OP) ? S_CMD : S_IDLE;
          end
          S_CMD: begin
            state <= S_IDLE;
            if (prog_read && !vec_pull) begin
              port_out[sel_out] <= cmd_val;
              if (hit) begin
                state    <= S_PEND_OP;
                arg_mode <= cmd_arg;
              end
            end
          end
          S_PEND_OP: begin
            if (op_fetch)
              state <= arg_mode ? S_PEND_ARG : S_WATCH;
          end
          S_PEND_ARG: state <= S_WATCH;
          default:    state <= S_IDLE;
        endcase
      end
    end
  end

  logic [DW-1:0] diff;
  assign diff = cpu_data ^ mem_data;

  a_r7_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !rwb |-> cpu_data == mem_data);

  a_r1_flip_only_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (diff == (DW'(1) << FLIP_BIT)) |-> (rwb && (mode_816 ? (vda && vpa) : sync)));

  a_r5_change_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (diff == '0) || (diff == (DW'(1) << FLIP_BIT)) || (diff == {DW{1'b1}}));

  a_r6_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    (diff != '0) |=> (diff == '0));

  a_r2_one_port_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_out ^ $past(port_out)) <= 1);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_flag |=> cancel_flag);

endmodule

// File: tb/opcode_flip_gate_bench.sv
`timescale 1ns/100ps
module opcode_flip_gate_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_816 = 1'b0, sync = 1'b0, vda = 1'b0, vpa = 1'b0, rwb = 1'b1, vec_pull = 1'b0;
  logic [7:0] mem_data = 8'h00, port_in = 8'h00;
  logic [7:0] cpu_data, port_out;
  logic       cancel_flag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  opcode_flip_gate u_opcode_flip_gate (
    .clk(clk), .rst_n(rst_n), .mode_816(mode_816), .sync(sync), .vda(vda), .vpa(vpa),
    .rwb(rwb), .vec_pull(vec_pull), .mem_data(mem_data), .port_in(port_in),
    .cpu_data(cpu_data), .port_out(port_out), .cancel_flag(cancel_flag)
  );

  // {mode_816,sync,vda,vpa,rwb,vec_pull}, mem, port_in, expected cpu, expected port after edge, req
  localparam int NV = 25;
  localparam logic [41:0] VEC [NV] = '{
    {6'b010010, 8'h42, 8'h00, 8'h42, 8'h00, 4'd1},  // R1 trigger fetch
    {6'b000010, 8'h0B, 8'h08, 8'h0B, 8'h00, 4'd2},  // R2 command: in3, out1=0
    {6'b000010, 8'hA5, 8'h00, 8'hA5, 8'h00, 4'd7},  // R7 data read
    {6'b000000, 8'h33, 8'h00, 8'h33, 8'h00, 4'd7},  // R7 write
    {6'b010010, 8'hA9, 8'h00, 8'h89, 8'h00, 4'd3},  // R3 bit 5 flipped
    {6'b000010, 8'h10, 8'h00, 8'h10, 8'h00, 4'd6},  // R6 operand untouched
    {6'b010010, 8'hA9, 8'h00, 8'hA9, 8'h00, 4'd6},  // R6 next opcode untouched
    {6'b010010, 8'h42, 8'h00, 8'h42, 8'h00, 4'd1},
    {6'b000010, 8'h0B, 8'h00, 8'h0B, 8'h00, 4'd4},  // R4 input low
    {6'b010010, 8'hA9, 8'h00, 8'hA9, 8'h00, 4'd4},
    {6'b010010, 8'h42, 8'h00, 8'h42, 8'h00, 4'd1},
    {6'b000010, 8'hD0, 8'h01, 8'hD0, 8'h04, 4'd5},  // R5 operand mode, out2=1
    {6'b010010, 8'h29, 8'h00, 8'h29, 8'h04, 4'd5},
    {6'b000010, 8'hF0, 8'h00, 8'h0F, 8'h04, 4'd5},  // R5 operand inverted
    {6'b010010, 8'hEA, 8'h00, 8'hEA, 8'h04, 4'd6},
    {6'b110010, 8'h42, 8'h00, 8'h42, 8'h04, 4'd11}, // R11 sync ignored in 816 mode
    {6'b101110, 8'h42, 8'h00, 8'h42, 8'h04, 4'd1},
    {6'b100110, 8'h0B, 8'h08, 8'h0B, 8'h04, 4'd2},
    {6'b110010, 8'hA9, 8'h00, 8'hA9, 8'h04, 4'd11},
    {6'b101010, 8'hA9, 8'h00, 8'hA9, 8'h04, 4'd7},
    {6'b101110, 8'hAD, 8'h00, 8'h8D, 8'h04, 4'd3},
    {6'b101110, 8'hAD, 8'h00, 8'hAD, 8'h04, 4'd6},
    {6'b001110, 8'h42, 8'h00, 8'h42, 8'h04, 4'd11}, // R11 vda/vpa ignored in 6502 mode
    {6'b000010, 8'h0B, 8'h08, 8'h0B, 8'h04, 4'd11},
    {6'b010010, 8'hA9, 8'h00, 8'hA9, 8'h04, 4'd11}
  };

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] ctl, input logic [7:0] mem, input logic [7:0] pin,
                      output logic [7:0] got);
    @(negedge clk);
    {mode_816, sync, vda, vpa, rwb, vec_pull} = ctl;
    mem_data = mem;
    port_in  = pin;
    #1 got = cpu_data;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {mode_816, sync, vda, vpa, rwb, vec_pull} = 6'b000010;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check8("R10", "port_out after reset", port_out, 8'h00);
    check8("R10", "cancel_flag after reset", {7'd0, cancel_flag}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][41:36], VEC[i][35:28], VEC[i][27:20], got);
      check8($sformatf("R%0d", VEC[i][3:0]), $sformatf("row %0d cpu_data", i), got, VEC[i][19:12]);
      check8($sformatf("R%0d", VEC[i][3:0]), $sformatf("row %0d port_out", i), port_out, VEC[i][11:4]);
    end
    check8("R8", "no cancel in table run", {7'd0, cancel_flag}, 8'h00);

    // R2 high output bit written to 1, others held: cmd 78h = out7, value 1, in0
    step(6'b010010, 8'h42, 8'h00, got);
    step(6'b000010, 8'h78, 8'h00, got);
    check8("R2", "bit7 set, bit2 held", port_out, 8'h84);

    // R8 vector pull before target
    do_reset();
    step(6'b010010, 8'h42, 8'h00, got);
    step(6'b000010, 8'h0B, 8'h08, got);
    step(6'b000011, 8'hFF, 8'h00, got);
    check8("R8", "vector byte untouched", got, 8'hFF);
    check8("R8", "cancel set", {7'd0, cancel_flag}, 8'h01);
    step(6'b010010, 8'hA9, 8'h00, got);
    check8("R8", "opcode after cancel", got, 8'hA9);
    step(6'b010010, 8'hEA, 8'h00, got);
    check8("R8", "cancel sticky", {7'd0, cancel_flag}, 8'h01);

    // R10 reset clears flag and discards a pending change
    step(6'b010010, 8'h42, 8'h00, got);
    step(6'b000010, 8'h0B, 8'h08, got);
    do_reset();
    check8("R10", "cancel cleared", {7'd0, cancel_flag}, 8'h00);
    step(6'b010010, 8'hA9, 8'h00, got);
    check8("R10", "pending discarded", got, 8'hA9);

    // R8 vector pull after altered opcode, before next fetch
    step(6'b010010, 8'h42, 8'h00, got);
    step(6'b000010, 8'h0B, 8'h08, got);
    step(6'b010010, 8'hA9, 8'h00, got);
    check8("R3", "flip before interrupt", got, 8'h89);
    step(6'b000010, 8'hA9, 8'h00, got);
    step(6'b000011, 8'hFE, 8'h00, got);
    check8("R8", "cancel after altered opcode", {7'd0, cancel_flag}, 8'h01);

    // R9 42h on a data read does not arm
    do_reset();
    step(6'b000010, 8'h42, 8'h00, got);
    step(6'b000010, 8'h0B, 8'h08, got);
    step(6'b010010, 8'hA9, 8'h00, got);
    check8("R9", "no arm from data read", got, 8'hA9);
    check8("R9", "port untouched", port_out, 8'h00);

    // R7 write cycle after trigger is not a command
    step(6'b010010, 8'h42, 8'h00, got);
    step(6'b000000, 8'h4B, 8'h08, got);
    check8("R7", "write passes", got, 8'h4B);
    step(6'b010010, 8'hA9, 8'h00, got);
    check8("R7", "write not taken as command", got, 8'hA9);
    check8("R7", "port after write", port_out, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule